// File: doc/BRIEF.md
# Half-Duplex Host Mailbox With Output Select

This block is the device end of a byte-wide host port. A two-bit select from the host decides what the device places on the read bus. The choices are the current byte of sample stream A, the current byte of sample stream B, a one-byte mailbox, or a fixed identification byte. The bus is combinational from the select, so the output follows within the same clock cycle. While a sample stream is selected, each falling edge of the host strobe sends a one-cycle advance pulse to that stream's read pointer.

The mailbox carries single bytes in both directions. Its value 0x00 means "empty", so a zero byte can never be sent through it. A side that writes a byte reads zero from then on, and the other side reads the byte, until the other side writes in turn. The host writes on a rising strobe edge while its write-intent line is high and the mailbox is selected. The internal side writes with a one-cycle enable. When both sides write in the same cycle, the host wins.

Ownership is a three-state machine. EMPTY is the state after reset, and in it both views read zero. TO_DEV is entered by a host write: the device reads the byte and the host reads zero. TO_HOST is entered by a device write: the host reads the byte and the device reads zero. The transitions are named as follows. HOST_WRITE goes from any state to TO_DEV. DEV_WRITE goes from EMPTY or TO_DEV to TO_HOST, and also from TO_HOST to TO_HOST when the host is not looking at the mailbox. HOLD covers every other cycle and leaves the state unchanged.

Top module: `host_mbox_port`

## Requirements
- R1: Select 2'b00 drives ch_a_data and select 2'b01 drives ch_b_data onto host_dout in the same cycle.
- R2: Select 2'b11 drives the ID_BYTE parameter (default 0x55) onto host_dout.
- R3: After reset the mailbox is empty: host_dout reads 0 with select 2'b10, and dev_rd_data reads 0.
- R4: A rising edge of host_strobe_n with host_init high and select 2'b10 stores host_din. From the next cycle dev_rd_data shows the byte and the host's mailbox view reads 0.
- R5: dev_wr_en with a nonzero dev_wr_data stores the byte. From the next cycle the host reads it through select 2'b10, and dev_rd_data reads 0.
- R6: A write of 0x00 from either side is ignored and leaves both views unchanged.
- R7: When a host write and a device write fall in the same cycle, the host byte is kept and the device byte is dropped.
- R8: A rising strobe edge with host_init low, or with a select other than 2'b10, writes nothing.
- R9: A falling strobe edge with select 2'b00 pulses ch_adv[0], and with select 2'b01 pulses ch_adv[1], for one cycle in that cycle. A strobe held low, or a falling edge with select 2'b10 or 2'b11, gives no pulse.
- R10: While the host has the mailbox selected and is reading a nonzero byte, a device write is dropped. This means the host-visible value changes only from zero to a valid byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Output select: bit 0 autofeed, bit 1 select-in |
| host_strobe_n | input | 1 | Host strobe, active low |
| host_init | input | 1 | Host write intent |
| host_din | input | W | Byte written by the host |
| host_dout | output | W | Byte driven to the host |
| ch_a_data | input | W | Current sample of stream A |
| ch_b_data | input | W | Current sample of stream B |
| ch_adv | output | 2 | Read-pointer advance pulses, bit 0 for A and bit 1 for B |
| dev_wr_en | input | 1 | Internal-side mailbox write enable |
| dev_wr_data | input | W | Internal-side mailbox write byte |
| dev_rd_data | output | W | Internal-side mailbox view, 0 when empty |

## Verification
The bench builds the block with the defaults, W = 8 and ID_BYTE = 0x55. With these values a byte written by one side can be compared exactly against the other side's view, and the identification value is a known constant. The behavioural model tracks ownership and the previous strobe level. This lets it reach the collision cycle, the zero-byte writes, and the drop of a device write while the host is looking.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
    typedef enum logic [1:0] {
        MB_EMPTY   = 2'd0,
        MB_TO_DEV  = 2'd1,
        MB_TO_HOST = 2'd2
    } mb_state_e;

    localparam logic [1:0] SEL_CHA  = 2'b00;
    localparam logic [1:0] SEL_CHB  = 2'b01;
    localparam logic [1:0] SEL_MBOX = 2'b10;
    localparam logic [1:0] SEL_ID   = 2'b11;
endpackage

// File: rtl/hpm_strobe_edge.sv
module hpm_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    assign rise = strobe_n & ~strobe_q;
    assign fall = ~strobe_n & strobe_q;
endmodule

// File: rtl/hpm_mailbox.sv
module hpm_mailbox
    import hpm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic [W-1:0] host_data,
    input  logic         host_looking,
    input  logic         dev_wr_en,
    input  logic [W-1:0] dev_wr_data,
    output logic [W-1:0] host_view,
    output logic [W-1:0] dev_view
);
    localparam logic [W-1:0] EMPTY_BYTE = '0;

    mb_state_e    state, state_nx;
    logic [W-1:0] data_q, data_nx;
    logic         host_take, dev_take;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MB_EMPTY;
            data_q <= EMPTY_BYTE;
        end else begin
            state  <= state_nx;
            data_q <= data_nx;
        end
    end

    // transitions: HOST_WRITE, DEV_WRITE, HOLD
    always_comb begin
        host_take = host_wr && (host_data != EMPTY_BYTE);
        dev_take  = dev_wr_en && (dev_wr_data != EMPTY_BYTE) && !host_take;
        state_nx  = state;
        data_nx   = data_q;
        unique case (state)
            MB_EMPTY, MB_TO_DEV: begin
                if (host_take) begin
                    state_nx = MB_TO_DEV;
                    data_nx  = host_data;
                end else if (dev_take) begin
                    state_nx = MB_TO_HOST;
                    data_nx  = dev_wr_data;
                end
            end
            MB_TO_HOST: begin
                if (host_take) begin
                    state_nx = MB_TO_DEV;
                    data_nx  = host_data;
                end else if (dev_take && !host_looking) begin
                    data_nx  = dev_wr_data;
                end
            end
            default: begin
                state_nx = MB_EMPTY;
                data_nx  = EMPTY_BYTE;
            end
        endcase
    end

    // outputs
    always_comb begin
        host_view = EMPTY_BYTE;
        dev_view  = EMPTY_BYTE;
        unique case (state)
            MB_TO_DEV:  dev_view  = data_q;
            MB_TO_HOST: host_view = data_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/hpm_port_mux.sv
module hpm_port_mux
    import hpm_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] ID_BYTE = 8'h55
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] ch_a,
    input  logic [W-1:0] ch_b,
    input  logic [W-1:0] mbox,
    output logic [W-1:0] dout
);
    always_comb begin
        unique case (sel)
            SEL_CHA:  dout = ch_a;
            SEL_CHB:  dout = ch_b;
            SEL_MBOX: dout = mbox;
            default:  dout = ID_BYTE;
        endcase
    end
endmodule

// File: rtl/host_mbox_port.sv
module host_mbox_port
    import hpm_pkg::*;
#(
    parameter int           W       = 8,
    parameter logic [W-1:0] ID_BYTE = 8'h55
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   host_sel,
    input  logic         host_strobe_n,
    input  logic         host_init,
    input  logic [W-1:0] host_din,
    output logic [W-1:0] host_dout,
    input  logic [W-1:0] ch_a_data,
    input  logic [W-1:0] ch_b_data,
    output logic [1:0]   ch_adv,
    input  logic         dev_wr_en,
    input  logic [W-1:0] dev_wr_data,
    output logic [W-1:0] dev_rd_data
);
    localparam int NUM_CH = 2;

    logic         stb_rise, stb_fall;
    logic         mbox_sel;
    logic         host_wr;
    logic [W-1:0] mb_host_view;

    hpm_strobe_edge edge_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (host_strobe_n),
        .rise     (stb_rise),
        .fall     (stb_fall)
    );

    assign mbox_sel = (host_sel == SEL_MBOX);
    assign host_wr  = stb_rise && host_init && mbox_sel;

    hpm_mailbox #(.W(W)) mbox_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr      (host_wr),
        .host_data    (host_din),
        .host_looking (mbox_sel),
        .dev_wr_en    (dev_wr_en),
        .dev_wr_data  (dev_wr_data),
        .host_view    (mb_host_view),
        .dev_view     (dev_rd_data)
    );

    hpm_port_mux #(.W(W), .ID_BYTE(ID_BYTE)) mux_i (
        .sel  (host_sel),
        .ch_a (ch_a_data),
        .ch_b (ch_b_data),
        .mbox (mb_host_view),
        .dout (host_dout)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_adv
        assign ch_adv[c] = stb_fall && (host_sel == 2'(c));
    end
endmodule

// File: rtl/host_mbox_port_chk.sv
module host_mbox_port_chk #(
    parameter int           W       = 8,
    parameter logic [W-1:0] ID_BYTE = 8'h55
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   host_sel,
    input logic [W-1:0] host_din,
    input logic [W-1:0] host_dout,
    input logic [1:0]   ch_adv,
    input logic         dev_wr_en,
    input logic [W-1:0] dev_wr_data,
    input logic [W-1:0] dev_rd_data,
    input logic         host_wr,
    input logic [W-1:0] mb_host_view
);
    p_id_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel == 2'b11 |-> host_dout == ID_BYTE);

    p_host_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_din != '0) |=> (dev_rd_data == $past(host_din) && mb_host_view == '0));

    p_dev_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr_en && dev_wr_data != '0 && !host_wr && !(host_sel == 2'b10 && host_dout != '0))
        |=> (mb_host_view == $past(dev_wr_data) && dev_rd_data == '0));

    p_one_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd_data != '0 && mb_host_view != '0));

    p_adv_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_adv));

    p_host_view_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_sel == 2'b10 && host_dout != '0 && !host_wr)
        |=> (host_sel != 2'b10 || $stable(host_dout)));
endmodule

bind host_mbox_port host_mbox_port_chk #(.W(W), .ID_BYTE(ID_BYTE)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_din     (host_din),
    .host_dout    (host_dout),
    .ch_adv       (ch_adv),
    .dev_wr_en    (dev_wr_en),
    .dev_wr_data  (dev_wr_data),
    .dev_rd_data  (dev_rd_data),
    .host_wr      (host_wr),
    .mb_host_view (mb_host_view)
);

// File: tb/host_mbox_port_tb_top.sv
`timescale 1ns/1ps
module host_mbox_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = 2'b00;
    logic       host_strobe_n = 1'b1;
    logic       host_init = 1'b0;
    logic [7:0] host_din = 8'h00;
    logic [7:0] host_dout;
    logic [7:0] ch_a_data = 8'h00;
    logic [7:0] ch_b_data = 8'h00;
    logic [1:0] ch_adv;
    logic       dev_wr_en = 1'b0;
    logic [7:0] dev_wr_data = 8'h00;
    logic [7:0] dev_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state: 0 empty, 1 host wrote, 2 device wrote
    int m_state = 0;
    int m_val = 0;
    int m_prev = 1;
    int cyc = 0;

    always #2.5 clk = ~clk;

    host_mbox_port dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_strobe_n(host_strobe_n),
        .host_init(host_init), .host_din(host_din), .host_dout(host_dout),
        .ch_a_data(ch_a_data), .ch_b_data(ch_b_data), .ch_adv(ch_adv),
        .dev_wr_en(dev_wr_en), .dev_wr_data(dev_wr_data), .dev_rd_data(dev_rd_data)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic step(string tag, int sel, int stb, int init, int din, int den, int dwd);
        int exp_dout, exp_dev, exp_adv, hw, dw;
        host_sel = 2'(sel); host_strobe_n = stb[0]; host_init = init[0];
        host_din = 8'(din); dev_wr_en = den[0]; dev_wr_data = 8'(dwd);
        ch_a_data = 8'(cyc * 3 + 1); ch_b_data = 8'(255 - cyc * 5);
        #1;
        case (sel)
            0: exp_dout = (cyc * 3 + 1) & 255;
            1: exp_dout = (255 - cyc * 5) & 255;
            2: exp_dout = (m_state == 2) ? m_val : 0;
            default: exp_dout = 'h55;
        endcase
        exp_dev = (m_state == 1) ? m_val : 0;
        exp_adv = 0;
        if (stb == 0 && m_prev == 1 && sel == 0) exp_adv = 1;
        if (stb == 0 && m_prev == 1 && sel == 1) exp_adv = 2;
        check(tag, "host_dout", int'(host_dout), exp_dout);
        check(tag, "dev_rd_data", int'(dev_rd_data), exp_dev);
        check(tag, "ch_adv", int'(ch_adv), exp_adv);
        hw = (stb == 1 && m_prev == 0 && init == 1 && sel == 2 && din != 0) ? 1 : 0;
        dw = (den == 1 && dwd != 0 && !(m_state == 2 && sel == 2)) ? 1 : 0;
        @(posedge clk);
        if (hw == 1) begin m_state = 1; m_val = din; end
        else if (dw == 1) begin m_state = 2; m_val = dwd; end
        m_prev = stb;
        cyc++;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R3: empty after reset
        step("R3", 2, 1, 0, 0, 0, 0);
        // R2: identification byte
        step("R2", 3, 1, 0, 0, 0, 0);
        // R1: stream data selected
        step("R1", 0, 1, 0, 0, 0, 0);
        step("R1", 1, 1, 0, 0, 0, 0);
        step("R1", 0, 1, 0, 0, 0, 0);
        // R9: advance pulses
        step("R9", 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 0, 0, 0);
        step("R9", 0, 1, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 0);
        step("R9", 1, 1, 0, 0, 0, 0);
        step("R9", 2, 0, 0, 0, 0, 0);
        step("R9", 3, 1, 0, 0, 0, 0);
        step("R9", 3, 0, 0, 0, 0, 0);
        step("R9", 3, 1, 0, 0, 0, 0);
        // R4: host write
        step("R4", 2, 0, 1, 'h3C, 0, 0);
        step("R4", 2, 1, 1, 'h3C, 0, 0);
        step("R4", 2, 1, 0, 0, 0, 0);
        step("R4", 0, 1, 0, 0, 0, 0);
        // R6: zero writes ignored
        step("R6", 2, 0, 1, 0, 0, 0);
        step("R6", 2, 1, 1, 0, 0, 0);
        step("R6", 0, 1, 0, 0, 1, 0);
        step("R6", 2, 1, 0, 0, 0, 0);
        // R5: device write
        step("R5", 0, 1, 0, 0, 1, 'hA7);
        step("R5", 2, 1, 0, 0, 0, 0);
        step("R5", 3, 1, 0, 0, 0, 0);
        // R10: device write while host looks is dropped
        step("R10", 2, 1, 0, 0, 1, 'h11);
        step("R10", 2, 1, 0, 0, 0, 0);
        step("R10", 0, 1, 0, 0, 1, 'h11);
        step("R10", 2, 1, 0, 0, 0, 0);
        // R8: rises that must not write
        step("R8", 2, 0, 0, 'h42, 0, 0);
        step("R8", 2, 1, 0, 'h42, 0, 0);
        step("R8", 0, 0, 1, 'h42, 0, 0);
        step("R8", 0, 1, 1, 'h42, 0, 0);
        step("R8", 2, 1, 0, 0, 0, 0);
        // R7: collision, host wins
        step("R7", 2, 0, 1, 'h5A, 0, 0);
        step("R7", 2, 1, 1, 'h5A, 1, 'h77);
        step("R7", 2, 1, 0, 0, 0, 0);
        step("R7", 3, 1, 0, 0, 0, 0);
        // R5: device reply after host write, then host overwrite
        step("R5", 1, 1, 0, 0, 1, 'hC3);
        step("R5", 2, 1, 0, 0, 0, 0);
        step("R4", 2, 0, 1, 'h81, 0, 0);
        step("R4", 2, 1, 1, 'h81, 0, 0);
        step("R4", 2, 1, 0, 0, 0, 0);
        // R3: reset empties mailbox
        rst_n = 1'b0;
        @(posedge clk);
        m_state = 0; m_val = 0; m_prev = 1;
        @(negedge clk);
        rst_n = 1'b1;
        step("R3", 2, 1, 0, 0, 0, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule